// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address stream for a synchronous burst memory. Either of two address strobes captures an external address and starts a burst. The strobes are one for the processor side and one for the controller side. On each later cycle where the advance input is high, the block steps the two lowest address bits through a four-beat sequence. The upper bits stay at the captured value for the whole burst.

A static order-select pin picks the sequence:
- Linear order adds the beat count to the starting low bits, modulo four.
- Interleaved order XORs the starting low bits with the beat count.

A strobe may arrive on any cycle, so a new address can be taken every clock and bursting is optional. Every port is a plain control or address pin. There is no data payload here, so no valid/ready handshake and no back-pressure are involved.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset sets `addr_out` and `beat_out` to zero on the clock edge after it is sampled.
- R2: When either `strobe_cpu` or `strobe_ctl` is high at a rising edge, `addr_out` equals the sampled `addr_in` and `beat_out` equals 0 after that edge.
- R3: With no strobe, a rising edge with `advance` high increments `beat_out` by one modulo 4. A rising edge with `advance` low leaves `addr_out` and `beat_out` unchanged.
- R4: With `order_sel` = 0 (linear), `addr_out[1:0]` equals (start low bits + `beat_out`) modulo 4.
- R5: With `order_sel` = 1 (interleaved), `addr_out[1:0]` equals start low bits XOR `beat_out`.
- R6: The fourth advance after a load returns `addr_out[1:0]` to the starting low bits and `beat_out` to 0.
- R7: When a strobe and `advance` are both high in the same cycle, the strobe wins: the new address is loaded and `beat_out` is 0.
- R8: `addr_out[ADDR_W-1:2]` changes only on a strobe or a reset.
- R9: A strobe on every consecutive cycle loads each new address with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | External address captured on a strobe |
| strobe_cpu | input | 1 | Processor-side burst start strobe |
| strobe_ctl | input | 1 | Controller-side burst start strobe |
| advance | input | 1 | Steps the burst by one beat |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order |
| addr_out | output | ADDR_W | Current address: held upper bits and generated low bits |
| beat_out | output | 2 | Beat index within the current burst |

## Verification
The bench sweeps every starting low-bit value under both orders, starts bursts from each strobe in turn, and interleaves idle cycles with advances. This exposes four kinds of fault:
- A design that used the wrong operator for one order produces the wrong second or fourth beat.
- A design that carried into the upper bits changes `addr_out[ADDR_W-1:2]` at the wrap.
- A design that let the advance input act while held low would drift on idle cycles.
- A design that did not wrap would fail the fifth-beat check.

Simultaneous strobe and advance, back-to-back loads, and a reset in mid-burst target a wrong priority, a lost load and an incomplete clear.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (rst)       base_q <= '0;
    else if (load) base_q <= addr_in;
  end

  // R2
  base_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> base_q == $past(addr_in));

  // R8
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(base_q));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  output logic [BEAT_W-1:0] beat_q
);
  always_ff @(posedge clk) begin
    if (rst)          beat_q <= '0;
    else if (load)    beat_q <= '0;
    else if (advance) beat_q <= beat_q + 1'b1;
  end

  // R7
  beat_restart_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> beat_q == '0);

  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && advance) |=> beat_q == BEAT_W'($past(beat_q) + 1));

  // R3
  beat_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !advance) |=> $stable(beat_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  input  burst_order_e      order,
  output logic [BEAT_W-1:0] cur_lo
);
  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;

  // Carry out of the low field is dropped so the sum wraps inside the burst.
  assign lin_lo = start_lo + beat;

  genvar b;
  generate
    for (b = 0; b < BEAT_W; b++) begin : g_ilv
      assign ilv_lo[b] = start_lo[b] ^ beat[b];
    end
  endgenerate

  always_comb begin
    unique case (order)
      ORDER_INTERLEAVE: cur_lo = ilv_lo;
      default:          cur_lo = lin_lo;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              advance,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out,
  output logic [$clog2(BURST_LEN)-1:0] beat_out
);
  localparam int BEAT_W = $clog2(BURST_LEN);

  logic              load;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] cur_lo;
  burst_order_e      order;

  assign load  = strobe_cpu | strobe_ctl;
  assign order = burst_order_e'(order_sel);

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk(clk), .rst(rst), .load(load), .addr_in(addr_in), .base_q(base_q)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk(clk), .rst(rst), .load(load), .advance(advance), .beat_q(beat_q)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_lo(base_q[BEAT_W-1:0]), .beat(beat_q), .order(order), .cur_lo(cur_lo)
  );

  assign addr_out = {base_q[ADDR_W-1:BEAT_W], cur_lo};
  assign beat_out = beat_q;

  // R6
  wrap_return_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && advance && beat_q == BEAT_W'(BURST_LEN - 1))
      |=> addr_out[BEAT_W-1:0] == base_q[BEAT_W-1:0]);

  // R8
  upper_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(addr_out[ADDR_W-1:BEAT_W]));
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          strobe_cpu = 1'b0;
  logic          strobe_ctl = 1'b0;
  logic          advance = 1'b0;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat_out;

  int n_cmp = 0;
  int n_bad = 0;

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BURST_LEN(4)) i_burst_addr_gen (
    .clk(clk), .rst(rst), .addr_in(addr_in), .strobe_cpu(strobe_cpu),
    .strobe_ctl(strobe_ctl), .advance(advance), .order_sel(order_sel),
    .addr_out(addr_out), .beat_out(beat_out)
  );

  function automatic logic [AW-1:0] expect_addr();
    logic [1:0] lo;
    lo = order_sel ? (m_base[1:0] ^ m_beat) : 2'(m_base[1:0] + m_beat);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(input string req);
    logic [AW-1:0] ea;
    ea = expect_addr();
    n_cmp++;
    if (addr_out !== ea || beat_out !== m_beat) begin
      n_bad++;
      $display("FAIL %s: addr_out=%h beat_out=%0d expected addr_out=%h beat_out=%0d",
               req, addr_out, beat_out, ea, m_beat);
    end
  endtask

  // One clock: drive at falling edge, update the model, compare 1 ns after the rising edge.
  task automatic step(input logic s_cpu, input logic s_ctl, input logic adv,
                      input logic [AW-1:0] a, input string req);
    @(negedge clk);
    strobe_cpu = s_cpu; strobe_ctl = s_ctl; advance = adv; addr_in = a;
    @(posedge clk);
    if (rst) begin m_base = '0; m_beat = '0; end
    else if (s_cpu || s_ctl) begin m_base = a; m_beat = '0; end
    else if (adv) m_beat = m_beat + 2'd1;
    #1;
    check(req);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    rst = 1'b1;
    step(0, 0, 0, '0, "R1");
    step(0, 0, 1, 18'h3ffff, "R1");
    rst = 1'b0;

    for (int mode = 0; mode < 2; mode++) begin
      order_sel = mode[0];
      for (int lo = 0; lo < 4; lo++) begin
        for (int sel = 0; sel < 2; sel++) begin
          a = {16'(16'hA5C3 ^ (lo * 16'h1111) ^ (sel * 16'h0F0F) ^ (mode * 16'h8001)), 2'(lo)};
          step(sel == 0, sel == 1, 0, a, "R2");
          step(0, 0, 1, a + 18'd1, mode ? "R5" : "R4");
          step(0, 0, 0, a + 18'd2, "R3");
          step(0, 0, 1, '0, mode ? "R5" : "R4");
          step(0, 0, 1, '0, "R8");
          step(0, 0, 1, '0, "R6");
          step(0, 0, 1, '0, "R8");
        end
      end
    end

    order_sel = 1'b1;
    step(1, 0, 0, 18'h12341, "R2");
    step(0, 0, 1, '0, "R5");
    step(0, 1, 1, 18'h2beef, "R7");
    step(1, 1, 1, 18'h00003, "R7");

    for (int i = 0; i < 8; i++) begin
      order_sel = i[0];
      step(i[1], !i[1], i[2], 18'(i * 18'h0a5a7 + 3), "R9");
    end

    step(0, 0, 1, '0, "R3");
    rst = 1'b1;
    step(0, 0, 1, '0, "R1");
    rst = 1'b0;
    step(0, 0, 0, '0, "R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule